// File: doc/BRIEF.md
# Relocation Bit-Mask Word Patcher

This block applies load-time relocation to one record of object code at a time. A record arrives as a header (start address, length in bytes, 12-bit relocation mask) and is followed by up to twelve 3-byte words on a separate stream. For every word whose mask bit is set, the block adds the load base (sampled when the header is accepted) to the word. All words are written to memory, patched or not. Each write goes to the record start address plus the load base plus three times the word's position in the record.

A length that is not a multiple of three leaves a short final word. That word is passed through unchanged, with byte enables that cover only the bytes present, and a warning flag is raised. A mask that asks for relocation of a slot that is not a complete word inside the record marks the record as bad. The block still drains the record's words, but it writes none of them. A length above 36 bytes is also rejected, and in that case no words are taken at all. A one-cycle done pulse closes every record.

All three data paths use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A source must keep valid and its payload steady until the transfer happens. The write port has a single output register. While that register is full and `wr_ready` is low, `w_ready` is low, so back-pressure from memory stalls the word stream directly.

Top module: `reloc_mask_patcher`

## Requirements
- R1: After reset, `rec_ready` is 1, and `w_ready`, `wr_valid`, `done`, `mask_err` and `align_warn` are all 0.
- R2: `rec_mask` bit 11 controls the first word and bit 11-i controls word i. A 1 makes the written data equal to word + `load_base`; a 0 writes the word unchanged.
- R3: The relocation sum is taken modulo 2^24, so a carry out of bit 23 is dropped.
- R4: Word i (counted from 0) is written to `wr_addr` = `rec_start` + `load_base`[ADDR_W-1:0] + 3*i, modulo 2^ADDR_W.
- R5: If `rec_len` mod 3 is 1 or 2, the final word is written unchanged with `wr_be` = 3'b100 or 3'b110 respectively. Bit 2 of `wr_be` enables `wr_data`[23:16], which carries the first byte. `align_warn` is raised. Every complete word is written with `wr_be` = 3'b111.
- R6: If any mask bit is set for a slot at or beyond floor(`rec_len`/3), `mask_err` is raised. The block still consumes ceil(`rec_len`/3) words but makes no write.
- R7: A `rec_len` above 36 raises `mask_err`. No word is consumed and no write is made.
- R8: `w_ready` is never high while `rec_ready` is high. Exactly ceil(`rec_len`/3) words are consumed for a record of legal length. After `done`, `w_ready` is 0.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values, and `w_ready` is 0.
- R10: `done` is a single-cycle pulse. It is asserted only after the record's last write has been accepted, and never together with `wr_valid`. A record of length 0 yields `done` with no words and no writes.
- R11: `mask_err` and `align_warn` describe the most recently accepted record. They are valid while `done` is high and hold until the next header is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_base | input | 24 | Load base, sampled when a header is accepted |
| rec_valid | input | 1 | Header valid |
| rec_ready | output | 1 | Header ready (block idle) |
| rec_start | input | ADDR_W | Record start address |
| rec_len | input | LEN_W | Record length in bytes |
| rec_mask | input | SLOTS | Relocation mask, MSB = first word |
| w_valid | input | 1 | Object word valid |
| w_ready | output | 1 | Object word ready |
| w_data | input | 24 | Object word, first byte in bits 23:16 |
| wr_valid | output | 1 | Memory write valid |
| wr_ready | input | 1 | Memory write ready |
| wr_addr | output | ADDR_W | Memory write byte address |
| wr_data | output | 24 | Memory write data |
| wr_be | output | 3 | Byte enables, bit 2 for bits 23:16 |
| done | output | 1 | One-cycle end-of-record pulse |
| mask_err | output | 1 | Record rejected: bad mask or length |
| align_warn | output | 1 | Length not a multiple of three |

## Verification
The directed records cover several cases. Sparse masks that cover only leading words show whether the mask bits map to words from the MSB. An all-ones mask with a base near 2^24 and a start address near the top of the address space shows whether the data sum and the address both wrap. Lengths of 31 and 29 produce one and two trailing bytes, which separate the two partial byte-enable codes. A set mask bit on the partial slot, a set mask bit on the last slot of a short record, and a length of 40 distinguish the drain-without-write error from the reject-without-consume error. Random records with random bases, random gaps on the word stream and random memory stalls then check the same expectations while back-pressure varies from cycle to cycle.

// File: rtl/reloc_pkg.sv
`timescale 1ns/1ps
package reloc_pkg;
  localparam int WORD_W     = 24;
  localparam int WORD_BYTES = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STREAM = 2'd1,
    ST_FIN    = 2'd2
  } patch_state_e;
endpackage

// File: rtl/reloc_mask_seq.sv
`timescale 1ns/1ps
// Mask sequencer: checks a header against its length and walks the mask
// one slot per consumed word.
module reloc_mask_seq #(
  parameter int SLOTS = 12,
  parameter int LEN_W = 6,
  parameter int IDX_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic [SLOTS-1:0] mask,
  input  logic             step,
  output logic             ld_err,
  output logic             ld_warn,
  output logic             ld_skip,
  output logic             reloc_bit,
  output logic             last_word,
  output logic [2:0]       tail_be
);
  localparam int MAX_LEN = reloc_pkg::WORD_BYTES * SLOTS;

  logic [LEN_W-1:0] nfull;
  logic [LEN_W-1:0] rem_full;
  logic [LEN_W-1:0] nwords_in;
  logic [SLOTS-1:0] legal;
  logic             too_long;

  logic [SLOTS-1:0] shift_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] nw_q;
  logic [LEN_W-1:0] rem_q;

  always_comb begin
    nfull     = len / LEN_W'(reloc_pkg::WORD_BYTES);
    rem_full  = len % LEN_W'(reloc_pkg::WORD_BYTES);
    nwords_in = nfull + LEN_W'(rem_full != '0);
    too_long  = int'(len) > MAX_LEN;
  end

  // Slot k is relocatable only when it is a complete word of the record.
  for (genvar k = 0; k < SLOTS; k++) begin : g_legal
    assign legal[SLOTS-1-k] = int'(nfull) > k;
  end

  assign ld_err  = too_long || (|(mask & ~legal));
  assign ld_warn = !too_long && (rem_full != '0);
  assign ld_skip = too_long || (nwords_in == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      idx_q   <= '0;
      nw_q    <= '0;
      rem_q   <= '0;
    end else if (load) begin
      shift_q <= mask;
      idx_q   <= '0;
      nw_q    <= IDX_W'(nwords_in);
      rem_q   <= rem_full;
    end else if (step) begin
      shift_q <= shift_q << 1;
      idx_q   <= idx_q + IDX_W'(1);
    end
  end

  assign reloc_bit = shift_q[SLOTS-1];
  assign last_word = (idx_q == nw_q - IDX_W'(1));

  always_comb begin
    tail_be = 3'b111;
    if (last_word && rem_q == LEN_W'(1)) tail_be = 3'b100;
    else if (last_word && rem_q == LEN_W'(2)) tail_be = 3'b110;
  end

  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (idx_q < nw_q)); // R8
endmodule

// File: rtl/reloc_addr_gen.sv
`timescale 1ns/1ps
// Running write address: start + base at load, advances one word per step.
module reloc_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int STRIDE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] base,
  input  logic              step,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= start + base;
    else if (step) addr_q <= addr_q + ADDR_W'(STRIDE);
  end

  assign addr = addr_q;
endmodule

// File: rtl/reloc_word_add.sv
`timescale 1ns/1ps
// Conditional modular add of the load base to one object word.
module reloc_word_add #(
  parameter int W = 24
) (
  input  logic [W-1:0] word,
  input  logic [W-1:0] base,
  input  logic         en,
  output logic [W-1:0] result
);
  assign result = en ? (word + base) : word;
endmodule

// File: rtl/reloc_mask_patcher.sv
`timescale 1ns/1ps
module reloc_mask_patcher #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 6,
  parameter int SLOTS  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [reloc_pkg::WORD_W-1:0] load_base,
  input  logic                        rec_valid,
  output logic                        rec_ready,
  input  logic [ADDR_W-1:0]           rec_start,
  input  logic [LEN_W-1:0]            rec_len,
  input  logic [SLOTS-1:0]            rec_mask,
  input  logic                        w_valid,
  output logic                        w_ready,
  input  logic [reloc_pkg::WORD_W-1:0] w_data,
  output logic                        wr_valid,
  input  logic                        wr_ready,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [reloc_pkg::WORD_W-1:0] wr_data,
  output logic [2:0]                  wr_be,
  output logic                        done,
  output logic                        mask_err,
  output logic                        align_warn
);
  import reloc_pkg::*;

  localparam int IDX_W = $clog2(SLOTS + 1);

  patch_state_e      state_q;
  logic [WORD_W-1:0] base_q;
  logic              ov_q;
  logic [ADDR_W-1:0] wa_q;
  logic [WORD_W-1:0] wd_q;
  logic [2:0]        wbe_q;
  logic              done_q;
  logic              err_q;
  logic              warn_q;

  logic              out_free;
  logic              acc_rec;
  logic              acc_word;
  logic              ld_err, ld_warn, ld_skip;
  logic              reloc_bit, last_word;
  logic [2:0]        tail_be;
  logic [ADDR_W-1:0] cur_addr;
  logic [WORD_W-1:0] patched;

  assign out_free  = !ov_q || wr_ready;
  assign rec_ready = (state_q == ST_IDLE);
  assign w_ready   = (state_q == ST_STREAM) && out_free;
  assign acc_rec   = rec_valid && rec_ready;
  assign acc_word  = w_valid && w_ready;

  reloc_mask_seq #(.SLOTS(SLOTS), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (acc_rec),
    .len       (rec_len),
    .mask      (rec_mask),
    .step      (acc_word),
    .ld_err    (ld_err),
    .ld_warn   (ld_warn),
    .ld_skip   (ld_skip),
    .reloc_bit (reloc_bit),
    .last_word (last_word),
    .tail_be   (tail_be)
  );

  reloc_addr_gen #(.ADDR_W(ADDR_W), .STRIDE(WORD_BYTES)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc_rec),
    .start (rec_start),
    .base  (load_base[ADDR_W-1:0]),
    .step  (acc_word),
    .addr  (cur_addr)
  );

  reloc_word_add #(.W(WORD_W)) u_add (
    .word   (w_data),
    .base   (base_q),
    .en     (reloc_bit),
    .result (patched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ov_q    <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
      wbe_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ov_q && wr_ready) ov_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (acc_rec) begin
            base_q  <= load_base;
            err_q   <= ld_err;
            warn_q  <= ld_warn;
            state_q <= ld_skip ? ST_FIN : ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (acc_word) begin
            if (!err_q) begin
              ov_q  <= 1'b1;
              wa_q  <= cur_addr;
              wd_q  <= patched;
              wbe_q <= tail_be;
            end
            if (last_word) state_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          if (out_free) begin
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid   = ov_q;
  assign wr_addr    = wa_q;
  assign wr_data    = wd_q;
  assign wr_be      = wbe_q;
  assign done       = done_q;
  assign mask_err   = err_q;
  assign align_warn = warn_q;

  AST_HOLD_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be))); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid); // R10
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |-> !wr_valid); // R6
  AST_HS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_ready && w_ready)); // R8
endmodule

// File: tb/test_reloc_mask_patcher.sv
`timescale 1ns/1ps
module test_reloc_mask_patcher;
  localparam int ADDR_W = 20;
  localparam int LEN_W  = 6;
  localparam int SLOTS  = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [23:0]       load_base = '0;
  logic              rec_valid = 1'b0;
  logic              rec_ready;
  logic [ADDR_W-1:0] rec_start = '0;
  logic [LEN_W-1:0]  rec_len = '0;
  logic [SLOTS-1:0]  rec_mask = '0;
  logic              w_valid = 1'b0;
  logic              w_ready;
  logic [23:0]       w_data = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr;
  logic [23:0]       wr_data;
  logic [2:0]        wr_be;
  logic              done;
  logic              mask_err;
  logic              align_warn;

  reloc_mask_patcher #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SLOTS(SLOTS)) i_reloc_mask_patcher (
    .clk(clk), .rst_n(rst_n), .load_base(load_base),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_start(rec_start),
    .rec_len(rec_len), .rec_mask(rec_mask),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .done(done),
    .mask_err(mask_err), .align_warn(align_warn)
  );

  always #5 clk = ~clk;

  int ntot = 0;
  int nfail = 0;
  int cycles = 0;

  logic [23:0]       wdat [SLOTS];
  logic [ADDR_W-1:0] got_addr [16];
  logic [23:0]       got_data [16];
  logic [2:0]        got_be [16];
  int                ngot;

  task automatic chk(input bit ok, input string req, input string what);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      ntot++;
      nfail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  function automatic logic [SLOTS-1:0] legal_mask(input int ln);
    logic [SLOTS-1:0] m = '0;
    for (int k = 0; k < SLOTS; k++) if (k < ln / 3) m[SLOTS-1-k] = 1'b1;
    return m;
  endfunction

  task automatic run_rec(input logic [ADDR_W-1:0] st, input int ln,
                         input logic [SLOTS-1:0] mk, input logic [23:0] bs,
                         input string tag);
    bit   too_long = ln > 36;
    bit   exp_err  = too_long || ((mk & ~legal_mask(ln)) != '0);
    bit   exp_warn = !too_long && (ln % 3 != 0);
    int   nwords   = too_long ? 0 : (ln + 2) / 3;
    int   nexp     = exp_err ? 0 : nwords;
    int   sent     = 0;
    bit   seen_done = 0;
    bit   hold_prev = 0;
    int   bp_viol  = 0;
    bit   wr_at_done = 0;
    bit   f_err = 0, f_warn = 0;
    logic [ADDR_W-1:0] h_addr;
    logic [23:0]       h_data;
    logic [2:0]        h_be;
    ngot = 0;
    @(negedge clk);
    load_base = bs;
    rec_start = st;
    rec_len   = LEN_W'(ln);
    rec_mask  = mk;
    rec_valid = 1'b1;
    for (int cyc = 0; cyc < 400 && !seen_done; cyc++) begin
      @(negedge clk);
      rec_valid = 1'b0;
      wr_ready  = ($urandom % 4) != 0;
      w_valid   = (sent < nwords) && (($urandom % 3) != 0);
      w_data    = wdat[sent < SLOTS ? sent : 0];
      #1;
      if (hold_prev && !(wr_valid && wr_addr == h_addr && wr_data == h_data && wr_be == h_be))
        bp_viol++;
      hold_prev = wr_valid && !wr_ready;
      h_addr = wr_addr; h_data = wr_data; h_be = wr_be;
      if (wr_valid && !wr_ready && w_ready) bp_viol++;
      if (wr_valid && wr_ready && ngot < 16) begin
        got_addr[ngot] = wr_addr; got_data[ngot] = wr_data; got_be[ngot] = wr_be;
        ngot++;
      end
      if (w_valid && w_ready) sent++;
      if (done) begin
        seen_done = 1;
        wr_at_done = wr_valid;
        f_err = mask_err;
        f_warn = align_warn;
      end
    end
    w_valid = 1'b0;
    chk(seen_done, "R10", $sformatf("%s done seen act=%0d exp=1", tag, seen_done));
    chk(!wr_at_done, "R10", $sformatf("%s wr_valid with done act=%0d exp=0", tag, wr_at_done));
    chk(f_err == exp_err, "R6", $sformatf("%s mask_err act=%0d exp=%0d", tag, f_err, exp_err));
    chk(f_warn == exp_warn, "R5", $sformatf("%s align_warn act=%0d exp=%0d", tag, f_warn, exp_warn));
    chk(sent == nwords, "R8", $sformatf("%s words consumed act=%0d exp=%0d", tag, sent, nwords));
    chk(ngot == nexp, too_long ? "R7" : "R6",
        $sformatf("%s write count act=%0d exp=%0d", tag, ngot, nexp));
    chk(bp_viol == 0, "R9", $sformatf("%s backpressure violations act=%0d exp=0", tag, bp_viol));
    for (int i = 0; i < nexp && i < ngot; i++) begin
      logic [ADDR_W-1:0] ea = st + bs[ADDR_W-1:0] + ADDR_W'(3 * i);
      bit                full = i < ln / 3;
      logic [23:0]       ed = (full && mk[SLOTS-1-i]) ? wdat[i] + bs : wdat[i];
      logic [2:0]        eb = full ? 3'b111 : ((ln % 3 == 1) ? 3'b100 : 3'b110);
      chk(got_addr[i] == ea, "R4", $sformatf("%s word %0d addr act=%h exp=%h", tag, i, got_addr[i], ea));
      chk(got_data[i] == ed, "R2 R3", $sformatf("%s word %0d data act=%h exp=%h", tag, i, got_data[i], ed));
      chk(got_be[i] == eb, "R5", $sformatf("%s word %0d be act=%b exp=%b", tag, i, got_be[i], eb));
    end
    @(negedge clk);
    #1;
    chk(!w_ready && rec_ready, "R8", $sformatf("%s after done w_ready=%0d rec_ready=%0d exp 0/1", tag, w_ready, rec_ready));
    chk(mask_err == exp_err && align_warn == exp_warn, "R11",
        $sformatf("%s flags held act=%0d%0d exp=%0d%0d", tag, mask_err, align_warn, exp_err, exp_warn));
  endtask

  task automatic fill_words();
    for (int i = 0; i < SLOTS; i++) wdat[i] = 24'($urandom);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(rec_ready == 1'b1 && w_ready == 1'b0 && wr_valid == 1'b0, "R1",
        $sformatf("reset ready/valid act=%0d%0d%0d exp=100", rec_ready, w_ready, wr_valid));
    chk(done == 1'b0 && mask_err == 1'b0 && align_warn == 1'b0, "R1",
        $sformatf("reset status act=%0d%0d%0d exp=000", done, mask_err, align_warn));

    fill_words(); run_rec(20'h01000, 30, 12'hFFC, 24'h002000, "R2 first ten");
    fill_words(); run_rec(20'h04000, 27, 12'hE00, 24'h000100, "R2 first three");
    for (int i = 0; i < SLOTS; i++) wdat[i] = 24'hFFFFF0 + 24'(i);
    run_rec(20'hFFFF0, 36, 12'hFFF, 24'hFFFFF8, "R3 R4 wrap");
    fill_words(); run_rec(20'h00100, 0, 12'h000, 24'h000010, "R10 empty");
    fill_words(); run_rec(20'h02000, 31, 12'hFFC, 24'h000300, "R5 one byte");
    fill_words(); run_rec(20'h02100, 29, 12'h0A0, 24'h000040, "R5 two bytes");
    fill_words(); run_rec(20'h03000, 32, 12'hFFE, 24'h000500, "R6 partial slot");
    fill_words(); run_rec(20'h03100, 6, 12'h001, 24'h000500, "R6 beyond");
    fill_words(); run_rec(20'h03200, 40, 12'h000, 24'h000500, "R7 too long");

    for (int r = 0; r < 40; r++) begin
      int ln = int'($urandom % 38);
      logic [SLOTS-1:0] mk = SLOTS'($urandom);
      if (($urandom % 4) != 0) mk = mk & legal_mask(ln);
      fill_words();
      run_rec(ADDR_W'($urandom), ln, mk, 24'($urandom), $sformatf("rand%0d", r));
    end

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule